// File: doc/BRIEF.md
# Conditional Branch and Skip Unit

This unit settles program-counter flow for the control-transfer instructions of a small 8-bit core. One operation is presented per cycle: an unconditional relative jump, a branch that tests one status flag for set or clear, or a skip that steps over the next instruction when a register comparison, a register bit or an I/O bit meets its condition. For each accepted operation the unit reports the next program counter, whether the branch was taken or the skip happened, and how many cycles the instruction costs.

The cost depends on the outcome. A jump always costs two cycles. A branch costs one cycle when it falls through and two when it is taken. A skip costs one cycle when its condition is false. When the condition is true, it costs two cycles if the instruction it steps over is one word long and three if that instruction is two words long. The signed-compare branch condition is formed inside the unit from the negative and overflow flags, so a stale combined flag in the status byte cannot mislead it. The program counter wraps modulo the program memory size.

Operands are sampled on the rising clock edge when `op_valid_i` is high, and the result is registered for the following cycle. The unit does not fetch instructions, does not handle the call/return stack and does not access the I/O bus.

Top module: `brsk_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid_o`, `taken_o`, `next_pc_o` and `cycles_o` become zero. This also holds when `op_valid_i` is high.
- R2: A relative jump (`op_kind_i` = 0) gives `next_pc_o` = pc + offset + 1, `taken_o` = 1 and `cycles_o` = 2.
- R3: A flag branch (`op_kind_i` = 1) selects a status bit by `flag_idx_i`: 0 = carry, 1 = zero, 2 = negative, 3 = overflow, 4 = signed, 5 = half carry, 6 = transfer, 7 = interrupt enable. With `sense_i` = 1 the branch is taken when that bit is 1; with `sense_i` = 0 it is taken when the bit is 0. When taken, the result is pc + offset + 1 with 2 cycles. When not taken, the result is pc + 1 with 1 cycle and `taken_o` = 0.
- R4: For `flag_idx_i` = 4, the unit uses negative xor overflow (status bits 2 and 3) and ignores status bit 4. Signed greater-or-equal is index 4 with sense 0; signed less-than is index 4 with sense 1.
- R5: A register-equality skip (`op_kind_i` = 2) is true when `reg_a_i` equals `reg_b_i`.
- R6: A register-bit skip (`op_kind_i` = 3) is true when bit `bit_idx_i` of `reg_a_i` equals `sense_i` (1 = skip if set, 0 = skip if clear).
- R7: An I/O-bit skip (`op_kind_i` = 4) is true when bit `bit_idx_i` of `io_byte_i` equals `sense_i`.
- R8: A true skip gives `taken_o` = 1 with pc + 2 and 2 cycles when `next_two_word_i` = 0, and with pc + 3 and 3 cycles when `next_two_word_i` = 1. A false skip gives `taken_o` = 0, pc + 1 and 1 cycle, whatever the value of `next_two_word_i`.
- R9: The offset is a signed two's-complement value sign-extended to the PC width. All PC sums wrap modulo 2^PC_W, in both directions.
- R10: Operation codes 5, 6 and 7 are not taken and give pc + 1 with 1 cycle.
- R11: Results appear on the outputs the cycle after `op_valid_i` is sampled high, with `out_valid_o` = 1. After a cycle in which `op_valid_i` is low, `out_valid_o` = 0 and `next_pc_o`, `taken_o` and `cycles_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid_i | input | 1 | Operation present this cycle |
| op_kind_i | input | 3 | 0 jump, 1 flag branch, 2 equality skip, 3 register-bit skip, 4 I/O-bit skip |
| pc_i | input | PC_W (9) | Address of the current instruction |
| offset_i | input | OFF_W (12) | Signed relative offset |
| flag_idx_i | input | 3 | Status bit selected by a branch |
| sense_i | input | 1 | 1 = act on set, 0 = act on clear |
| status_i | input | DATA_W (8) | Status byte |
| reg_a_i | input | DATA_W (8) | First register operand |
| reg_b_i | input | DATA_W (8) | Second register operand |
| bit_idx_i | input | 3 | Bit tested by bit skips |
| io_byte_i | input | DATA_W (8) | I/O register value for I/O-bit skips |
| next_two_word_i | input | 1 | The following instruction is two words long |
| out_valid_o | output | 1 | Result registered this cycle |
| next_pc_o | output | PC_W (9) | Next program counter |
| taken_o | output | 1 | Branch taken or skip performed |
| cycles_o | output | 2 | Cycles the instruction uses |

## Verification
The assertions assume that the operand inputs are stable and defined at each sampling edge whenever `op_valid_i` is high. They also assume that the outcome of an operation is judged only by the registered result one cycle later. The stimulus drives every input on the falling edge and keeps it steady across the following rising edge. The stimulus also covers codes outside the defined operation set, so the rule that undefined codes fall through is exercised rather than assumed. Offsets include large and negative values that carry the PC past either end of its range.

// File: rtl/brsk_pkg.sv
// Package brsk_pkg
// Holds shared operation codes, status bit positions and path selects for
// the branch/skip unit. Assumes an 8-bit status byte layout with fixed
// bit positions that the flag index decodes.
package brsk_pkg;

    typedef enum logic [2:0] {
        OP_JUMP       = 3'd0,
        OP_BRANCH     = 3'd1,
        OP_SKIP_EQ    = 3'd2,
        OP_SKIP_RBIT  = 3'd3,
        OP_SKIP_IOBIT = 3'd4
    } op_kind_e;

    typedef enum logic [1:0] {
        PATH_SEQ  = 2'd0,
        PATH_REL  = 2'd1,
        PATH_SKIP = 2'd2
    } path_e;

    localparam int FLAG_NEG = 2;
    localparam int FLAG_OVF = 3;
    localparam int FLAG_SGN = 4;

endpackage

// File: rtl/brsk_cond.sv
// Module brsk_cond
// Evaluates the condition of a branch or skip and selects the PC path.
// Assumes that status bit FLAG_SGN is rebuilt from the negative and
// overflow bits, so the stored value of that bit is never used.
module brsk_cond
    import brsk_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [2:0]        kind,
    input  logic [IDX_W-1:0]  flag_idx,
    input  logic              sense,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] reg_a,
    input  logic [DATA_W-1:0] reg_b,
    input  logic [IDX_W-1:0]  bit_idx,
    input  logic [DATA_W-1:0] io_byte,
    output logic              take,
    output path_e             path
);

    logic [DATA_W-1:0] eff_flags;

    // Build the effective flag vector, replacing the signed bit by N xor V
    for (genvar i = 0; i < DATA_W; i++) begin : g_flag
        if (i == FLAG_SGN) begin : g_sgn
            assign eff_flags[i] = status[FLAG_NEG] ^ status[FLAG_OVF];
        end else begin : g_raw
            assign eff_flags[i] = status[i];
        end
    end

    // Decide the outcome and the PC path for the presented operation kind
    always_comb begin
        take = 1'b0;
        path = PATH_SEQ;
        case (op_kind_e'(kind))
            OP_JUMP: begin
                take = 1'b1;
                path = PATH_REL;
            end
            OP_BRANCH: begin
                take = (eff_flags[flag_idx] == sense);
                path = take ? PATH_REL : PATH_SEQ;
            end
            OP_SKIP_EQ: begin
                take = (reg_a == reg_b);
                path = take ? PATH_SKIP : PATH_SEQ;
            end
            OP_SKIP_RBIT: begin
                take = (reg_a[bit_idx] == sense);
                path = take ? PATH_SKIP : PATH_SEQ;
            end
            OP_SKIP_IOBIT: begin
                take = (io_byte[bit_idx] == sense);
                path = take ? PATH_SKIP : PATH_SEQ;
            end
            default: begin
                take = 1'b0;
                path = PATH_SEQ;
            end
        endcase
    end

endmodule

// File: rtl/brsk_target.sv
// Module brsk_target
// Computes the next PC and the cycle cost for a chosen path.
// Assumes that sums wrap modulo 2**PC_W. The offset is sign-extended when it
// is narrower than the PC, or truncated when it is wider; both give the
// same result modulo 2**PC_W.
module brsk_target
    import brsk_pkg::*;
#(
    parameter int PC_W  = 9,
    parameter int OFF_W = 12
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [OFF_W-1:0] offset,
    input  path_e            path,
    input  logic             two_word,
    output logic [PC_W-1:0]  next_pc,
    output logic [1:0]       cycles
);

    logic [PC_W-1:0] off_ext;

    // Fit the offset to the PC width; the parameters pick the variant
    if (OFF_W >= PC_W) begin : g_trunc
        assign off_ext = offset[PC_W-1:0];
    end else begin : g_sext
        assign off_ext = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};
    end

    // Select the PC step and cost for the path
    always_comb begin
        case (path)
            PATH_REL: begin
                next_pc = pc + off_ext + PC_W'(1);
                cycles  = 2'd2;
            end
            PATH_SKIP: begin
                next_pc = pc + (two_word ? PC_W'(3) : PC_W'(2));
                cycles  = two_word ? 2'd3 : 2'd2;
            end
            default: begin
                next_pc = pc + PC_W'(1);
                cycles  = 2'd1;
            end
        endcase
    end

endmodule

// File: rtl/brsk_unit.sv
// Module brsk_unit
// Top-level branch/skip unit. It samples one operation per cycle when
// op_valid_i is high and registers the next PC, the outcome and the cost.
// Assumes operands are stable around the sampling edge. Results are held
// while no operation is presented.
module brsk_unit
    import brsk_pkg::*;
#(
    parameter int PC_W   = 9,
    parameter int OFF_W  = 12,
    parameter int DATA_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      op_valid_i,
    input  logic [2:0]                op_kind_i,
    input  logic [PC_W-1:0]           pc_i,
    input  logic [OFF_W-1:0]          offset_i,
    input  logic [$clog2(DATA_W)-1:0] flag_idx_i,
    input  logic                      sense_i,
    input  logic [DATA_W-1:0]         status_i,
    input  logic [DATA_W-1:0]         reg_a_i,
    input  logic [DATA_W-1:0]         reg_b_i,
    input  logic [$clog2(DATA_W)-1:0] bit_idx_i,
    input  logic [DATA_W-1:0]         io_byte_i,
    input  logic                      next_two_word_i,
    output logic                      out_valid_o,
    output logic [PC_W-1:0]           next_pc_o,
    output logic                      taken_o,
    output logic [1:0]                cycles_o
);

    logic            take_c;
    path_e           path_c;
    logic [PC_W-1:0] next_pc_c;
    logic [1:0]      cycles_c;

    brsk_cond #(.DATA_W(DATA_W)) u_cond (
        .kind     (op_kind_i),
        .flag_idx (flag_idx_i),
        .sense    (sense_i),
        .status   (status_i),
        .reg_a    (reg_a_i),
        .reg_b    (reg_b_i),
        .bit_idx  (bit_idx_i),
        .io_byte  (io_byte_i),
        .take     (take_c),
        .path     (path_c)
    );

    brsk_target #(.PC_W(PC_W), .OFF_W(OFF_W)) u_target (
        .pc       (pc_i),
        .offset   (offset_i),
        .path     (path_c),
        .two_word (next_two_word_i),
        .next_pc  (next_pc_c),
        .cycles   (cycles_c)
    );

    // Register the result of an accepted operation; hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            next_pc_o   <= '0;
            taken_o     <= 1'b0;
            cycles_o    <= 2'd0;
        end else begin
            out_valid_o <= op_valid_i;
            if (op_valid_i) begin
                next_pc_o <= next_pc_c;
                taken_o   <= take_c;
                cycles_o  <= cycles_c;
            end
        end
    end

    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i |=> out_valid_o);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid_i |=> (!out_valid_o && $stable(next_pc_o) && $stable(cycles_o)));

    // R2
    jump_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_kind_i == OP_JUMP) |=> (taken_o && cycles_o == 2'd2));

    // R8
    skip_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && next_two_word_i &&
         (op_kind_i == OP_SKIP_EQ || op_kind_i == OP_SKIP_RBIT || op_kind_i == OP_SKIP_IOBIT))
        |=> (!taken_o || cycles_o == 2'd3));

    // R3
    fall_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid_i |=> (taken_o || (cycles_o == 2'd1 &&
                                    next_pc_o == PC_W'($past(pc_i) + PC_W'(1)))));

    // R10
    bad_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && op_kind_i > 3'd4) |=> !taken_o);

endmodule

// File: tb/brsk_unit_tb.sv
`timescale 1ns/1ps
module brsk_unit_tb;

    localparam int PC_W   = 9;
    localparam int OFF_W  = 12;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [3:0]       req;
        logic [2:0]       kind;
        logic [PC_W-1:0]  pc;
        logic [OFF_W-1:0] off;
        logic [2:0]       idx;
        logic             sense;
        logic [7:0]       status;
        logic [7:0]       a;
        logic [7:0]       b;
        logic [2:0]       bitn;
        logic [7:0]       io;
        logic             two;
        logic [PC_W-1:0]  epc;
        logic             etk;
        logic [1:0]       ecyc;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [0:NV-1] = '{
        // R2 jump forward
        '{4'd2, 3'd0, 9'd100, 12'd20,   3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd121, 1'b1, 2'd2},
        // R9 jump backward
        '{4'd9, 3'd0, 9'd10,  12'hFEC,  3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd503, 1'b1, 2'd2},
        // R9 jump wraps past the top
        '{4'd9, 3'd0, 9'd510, 12'd5,    3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd4,   1'b1, 2'd2},
        // R3 branch if zero set, taken
        '{4'd3, 3'd1, 9'd50,  12'd7,    3'd1, 1'b1, 8'h02, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd58,  1'b1, 2'd2},
        // R3 branch if zero set, not taken
        '{4'd3, 3'd1, 9'd50,  12'd7,    3'd1, 1'b1, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd51,  1'b0, 2'd1},
        // R3 branch if carry clear, taken backward
        '{4'd3, 3'd1, 9'd50,  12'hFFD,  3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd48,  1'b1, 2'd2},
        // R3 branch if carry clear, not taken
        '{4'd3, 3'd1, 9'd50,  12'hFFD,  3'd0, 1'b0, 8'h01, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd51,  1'b0, 2'd1},
        // R4 signed greater-or-equal, N=1 V=1
        '{4'd4, 3'd1, 9'd200, 12'd10,   3'd4, 1'b0, 8'h0C, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd211, 1'b1, 2'd2},
        // R4 signed less-than, N=1 V=0, stored signed bit 0
        '{4'd4, 3'd1, 9'd200, 12'd10,   3'd4, 1'b1, 8'h04, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd211, 1'b1, 2'd2},
        // R4 signed less-than, N=0 V=0, stored signed bit 1 ignored
        '{4'd4, 3'd1, 9'd200, 12'd10,   3'd4, 1'b1, 8'h10, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd201, 1'b0, 2'd1},
        // R3 branch if transfer flag set
        '{4'd3, 3'd1, 9'd300, 12'd0,    3'd6, 1'b1, 8'h40, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd301, 1'b1, 2'd2},
        // R5 equal registers, one-word skip
        '{4'd5, 3'd2, 9'd40,  12'd9,    3'd0, 1'b0, 8'h00, 8'h05, 8'h05, 3'd0, 8'h00, 1'b0, 9'd42,  1'b1, 2'd2},
        // R5 unequal registers
        '{4'd5, 3'd2, 9'd40,  12'd9,    3'd0, 1'b0, 8'h00, 8'h05, 8'h06, 3'd0, 8'h00, 1'b0, 9'd41,  1'b0, 2'd1},
        // R8 equal registers, two-word skip
        '{4'd8, 3'd2, 9'd40,  12'd0,    3'd0, 1'b0, 8'h00, 8'h05, 8'h05, 3'd0, 8'h00, 1'b1, 9'd43,  1'b1, 2'd3},
        // R6 register bit set, skip if set
        '{4'd6, 3'd3, 9'd60,  12'd0,    3'd0, 1'b1, 8'h00, 8'h08, 8'h00, 3'd3, 8'h00, 1'b0, 9'd62,  1'b1, 2'd2},
        // R6 register bit set, skip if clear
        '{4'd6, 3'd3, 9'd60,  12'd0,    3'd0, 1'b0, 8'h00, 8'h08, 8'h00, 3'd3, 8'h00, 1'b0, 9'd61,  1'b0, 2'd1},
        // R7 I/O bit clear, two-word skip
        '{4'd7, 3'd4, 9'd70,  12'd0,    3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd7, 8'h7F, 1'b1, 9'd73,  1'b1, 2'd3},
        // R9 I/O bit set skip wraps from the last word
        '{4'd9, 3'd4, 9'd511, 12'd0,    3'd0, 1'b1, 8'h00, 8'h00, 8'h00, 3'd0, 8'h01, 1'b0, 9'd1,   1'b1, 2'd2},
        // R10 undefined kind 5
        '{4'd10,3'd5, 9'd80,  12'd30,   3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd81,  1'b0, 2'd1},
        // R10 undefined kind 7 with everything active
        '{4'd10,3'd7, 9'd80,  12'd30,   3'd1, 1'b1, 8'hFF, 8'h01, 8'h01, 3'd0, 8'hFF, 1'b1, 9'd81,  1'b0, 2'd1},
        // R8 false skip ignores the two-word flag
        '{4'd8, 3'd2, 9'd90,  12'd0,    3'd0, 1'b0, 8'h00, 8'h01, 8'h02, 3'd0, 8'h00, 1'b1, 9'd91,  1'b0, 2'd1},
        // R3 branch if interrupt enable clear
        '{4'd3, 3'd1, 9'd100, 12'd2,    3'd7, 1'b0, 8'h7F, 8'h00, 8'h00, 3'd0, 8'h00, 1'b0, 9'd103, 1'b1, 2'd2},
        // R2 largest positive offset wraps to zero
        '{4'd2, 3'd0, 9'd0,   12'h7FF,  3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 3'd0, 8'h00, 1'b1, 9'd0,   1'b1, 2'd2}
    };

    logic              clk = 1'b0;
    logic              rst_n;
    logic              op_valid_i;
    logic [2:0]        op_kind_i;
    logic [PC_W-1:0]   pc_i;
    logic [OFF_W-1:0]  offset_i;
    logic [2:0]        flag_idx_i;
    logic              sense_i;
    logic [7:0]        status_i;
    logic [7:0]        reg_a_i;
    logic [7:0]        reg_b_i;
    logic [2:0]        bit_idx_i;
    logic [7:0]        io_byte_i;
    logic              next_two_word_i;
    logic              out_valid_o;
    logic [PC_W-1:0]   next_pc_o;
    logic              taken_o;
    logic [1:0]        cycles_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    brsk_unit #(.PC_W(PC_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .op_valid_i      (op_valid_i),
        .op_kind_i       (op_kind_i),
        .pc_i            (pc_i),
        .offset_i        (offset_i),
        .flag_idx_i      (flag_idx_i),
        .sense_i         (sense_i),
        .status_i        (status_i),
        .reg_a_i         (reg_a_i),
        .reg_b_i         (reg_b_i),
        .bit_idx_i       (bit_idx_i),
        .io_byte_i       (io_byte_i),
        .next_two_word_i (next_two_word_i),
        .out_valid_o     (out_valid_o),
        .next_pc_o       (next_pc_o),
        .taken_o         (taken_o),
        .cycles_o        (cycles_o)
    );

    task automatic check_out(input string tag, input logic ev, input logic [PC_W-1:0] epc,
                             input logic etk, input logic [1:0] ecyc);
        checks++;
        if (out_valid_o !== ev || next_pc_o !== epc || taken_o !== etk || cycles_o !== ecyc) begin
            errors++;
            $display("FAIL %s: got valid=%0b pc=%0d taken=%0b cycles=%0d, expected valid=%0b pc=%0d taken=%0b cycles=%0d",
                     tag, out_valid_o, next_pc_o, taken_o, cycles_o, ev, epc, etk, ecyc);
        end
    endtask

    task automatic drive(input vec_t v);
        op_kind_i       = v.kind;
        pc_i            = v.pc;
        offset_i        = v.off;
        flag_idx_i      = v.idx;
        sense_i         = v.sense;
        status_i        = v.status;
        reg_a_i         = v.a;
        reg_b_i         = v.b;
        bit_idx_i       = v.bitn;
        io_byte_i       = v.io;
        next_two_word_i = v.two;
    endtask

    initial begin
        rst_n = 1'b0;
        op_valid_i = 1'b0;
        drive(VECS[0]);
        repeat (3) @(negedge clk);
        // R1 reset state
        check_out("R1 reset", 1'b0, '0, 1'b0, 2'd0);
        rst_n = 1'b1;

        // Table walk: drive at a falling edge, check at the next falling edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            op_valid_i = 1'b1;
            drive(VECS[i]);
            @(negedge clk);
            check_out($sformatf("R%0d vector %0d", VECS[i].req, i),
                      1'b1, VECS[i].epc, VECS[i].etk, VECS[i].ecyc);
        end

        // R11 hold while idle: load a known result, then drop op_valid_i
        drive(VECS[0]);
        @(negedge clk);
        check_out("R11 load", 1'b1, 9'd121, 1'b1, 2'd2);
        op_valid_i = 1'b0;
        pc_i = 9'd400;
        op_kind_i = 3'd2;
        @(negedge clk);
        check_out("R11 idle hold", 1'b0, 9'd121, 1'b1, 2'd2);
        @(negedge clk);
        check_out("R11 idle hold 2", 1'b0, 9'd121, 1'b1, 2'd2);

        // R1 reset with an operation presented
        op_valid_i = 1'b1;
        drive(VECS[13]);
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R1 reset overrides op", 1'b0, '0, 1'b0, 2'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 first result after reset
        check_out("R8 after reset", 1'b1, 9'd43, 1'b1, 2'd3);
        op_valid_i = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule